// File: doc/BRIEF.md
# Bus Access Breakpoint Comparator

This block watches one processor bus cycle at a time and raises a break request when the cycle matches a programmed breakpoint. Each cycle presents an address, a data value, an access size, a direction and a flag that marks an instruction fetch. The breakpoint is set up through configuration ports. It holds an address, a data value, a per-bit data mask, an optional operand-size condition, a direction condition and a data-compare enable.

The address test depends on the access size. The low address bits that lie inside the accessed unit are left out of the comparison. A breakpoint placed on a byte therefore also catches the word and longword accesses that cover it. When the data test is enabled, it looks at the byte lane or halfword lane that the access uses. Upper configuration bits are ignored for narrow accesses. For a byte break, software places the same byte value in both low byte positions of the data and mask registers. A fetch cycle never takes part in a data comparison. The break request is registered and sticky, and it stays high until it is acknowledged.

Top module: `bus_brk_cmp`

## Requirements
- R1: When bus_size is 2 (longword), the address test compares bus_addr[31:2] with cfg_addr[31:2] only.
- R2: When bus_size is 1 (word), the address test compares bits 31:1 of both addresses.
- R3: When bus_size is 0 (byte), all 32 address bits are compared. A bus_size of 3 never matches.
- R4: cfg_size selects the operand-size condition: 0 byte, 1 word, 2 longword, 3 any. For codes 0 to 2, bus_size must equal cfg_size.
- R5: cfg_dir[0] enables matching on reads (bus_write=0) and cfg_dir[1] enables matching on writes. A fetch counts as a read.
- R6: With cfg_dcmp_en=1 on a data cycle, a hit needs both the address condition and the data condition. A data bit whose cfg_mask bit is 1 is a don't-care; a bit whose mask bit is 0 must equal cfg_data. A longword compares all 32 bits.
- R7: For word and byte accesses, cfg_data[31:16] and cfg_mask[31:16] have no effect. A word at bus_addr[1]=1 uses bus_data[31:16], otherwise bus_data[15:0], and it is compared against cfg_data[15:0].
- R8: A byte at offset k=bus_addr[1:0] uses bus_data[8k+7:8k]. It is compared against cfg_data[15:8] under cfg_mask[15:8] when bus_addr[0]=1, and against cfg_data[7:0] under cfg_mask[7:0] otherwise.
- R9: On a fetch cycle (bus_fetch=1), cfg_data and cfg_mask have no effect, even when the data compare is enabled.
- R10: brk_req is 0 after reset. It becomes 1 at the clock edge that samples a hit, and it then stays 1 until an edge where brk_ack=1 and no hit is sampled. A hit wins over an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Bus byte address |
| bus_data | input | 32 | Bus data, byte lane k in bits 8k+7:8k |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_write | input | 1 | 1 for a write cycle |
| bus_fetch | input | 1 | 1 for an instruction fetch cycle |
| cfg_addr | input | 32 | Breakpoint address |
| cfg_data | input | 32 | Breakpoint data |
| cfg_mask | input | 32 | Data mask, 1 = don't-care |
| cfg_size | input | 2 | Size condition, 3 = any |
| cfg_dir | input | 2 | bit0 reads, bit1 writes |
| cfg_dcmp_en | input | 1 | Include data in the condition |
| brk_ack | input | 1 | Clears a pending break |
| brk_req | output | 1 | Sticky break request |

## Verification
The hardest case to reach is the interplay of size-dependent address truncation with lane selection. A hit can depend both on which low address bits are dropped and on which half of the low configuration word is used. The stimulus sweeps every size across every offset around the breakpoint address. Byte data is placed only in the lane that the offset selects, with the other lanes filled with a different value. Partial masks and dirty upper configuration bits are then applied, so that a lane or mask error changes the outcome. Sticky behaviour is tested by withholding the acknowledge and by raising it in the same cycle as a hit.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_ANY  = 2'd3
   } size_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/bbc_addr_match.sv
module bbc_addr_match
   import bbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] brk_addr,
   input  logic [1:0]        size,
   output logic              hit
);
   localparam int unsigned LOW_W = 2;

   initial begin
      if (ADDR_W <= LOW_W) $error("ADDR_W must exceed %0d", LOW_W);
   end

   logic [ADDR_W-1:0] keep;
   logic              size_ok;

   always_comb begin
      keep    = '1;
      size_ok = 1'b1;
      unique case (size_e'(size))
         SZ_BYTE: keep = '1;
         SZ_WORD: keep[0] = 1'b0;
         SZ_LONG: keep[LOW_W-1:0] = '0;
         default: size_ok = 1'b0;
      endcase
   end

   assign hit = size_ok && (((addr ^ brk_addr) & keep) == '0);
endmodule

// File: rtl/bbc_data_match.sv
module bbc_data_match
   import bbc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] brk_data,
   input  logic [DATA_W-1:0] brk_mask,
   input  logic [1:0]        offs,
   input  logic [1:0]        size,
   output logic              hit
);
   localparam int unsigned LANES  = DATA_W / LANE_W;
   localparam int unsigned HALF_W = DATA_W / 2;

   initial begin
      if (DATA_W != 32) $error("DATA_W must be 32 for four byte lanes");
   end

   logic [LANE_W-1:0] lane [LANES];
   logic [HALF_W-1:0] half [2];

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         assign lane[gi] = data[gi*LANE_W +: LANE_W];
      end
      for (gi = 0; gi < 2; gi++) begin : g_half
         assign half[gi] = data[gi*HALF_W +: HALF_W];
      end
   endgenerate

   logic [LANE_W-1:0] byte_ref, byte_msk, byte_bus;
   logic [HALF_W-1:0] word_ref, word_msk, word_bus;

   always_comb begin
      byte_bus = lane[offs];
      byte_ref = offs[0] ? brk_data[2*LANE_W-1:LANE_W] : brk_data[LANE_W-1:0];
      byte_msk = offs[0] ? brk_mask[2*LANE_W-1:LANE_W] : brk_mask[LANE_W-1:0];
      word_bus = half[offs[1]];
      word_ref = brk_data[HALF_W-1:0];
      word_msk = brk_mask[HALF_W-1:0];
      unique case (size_e'(size))
         SZ_BYTE: hit = ((byte_bus ^ byte_ref) & ~byte_msk) == '0;
         SZ_WORD: hit = ((word_bus ^ word_ref) & ~word_msk) == '0;
         SZ_LONG: hit = ((data ^ brk_data) & ~brk_mask) == '0;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/bbc_sticky.sv
module bbc_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= 1'b0;
      else if (set)  q <= 1'b1;
      else if (clr)  q <= 1'b0;
   end
endmodule

// File: rtl/bus_brk_cmp.sv
module bus_brk_cmp
   import bbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [1:0]        bus_size,
   input  logic              bus_write,
   input  logic              bus_fetch,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic [DATA_W-1:0] cfg_mask,
   input  logic [1:0]        cfg_size,
   input  logic [1:0]        cfg_dir,
   input  logic              cfg_dcmp_en,
   input  logic              brk_ack,
   output logic              brk_req
);
   logic addr_hit, data_hit, size_hit, dir_hit, hit;

   bbc_addr_match #(.ADDR_W(ADDR_W)) u_addr (
      .addr     (bus_addr),
      .brk_addr (cfg_addr),
      .size     (bus_size),
      .hit      (addr_hit)
   );

   bbc_data_match #(.DATA_W(DATA_W)) u_data (
      .data     (bus_data),
      .brk_data (cfg_data),
      .brk_mask (cfg_mask),
      .offs     (bus_addr[1:0]),
      .size     (bus_size),
      .hit      (data_hit)
   );

   assign size_hit = (size_e'(cfg_size) == SZ_ANY) || (cfg_size == bus_size);
   assign dir_hit  = (bus_write && !bus_fetch) ? cfg_dir[1] : cfg_dir[0];
   assign hit      = bus_valid && addr_hit && size_hit && dir_hit &&
                     (bus_fetch || !cfg_dcmp_en || data_hit);

   bbc_sticky u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hit),
      .clr   (brk_ack),
      .q     (brk_req)
   );
endmodule

// File: rtl/bbc_chk.sv
module bbc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_valid,
   input logic [1:0] bus_size,
   input logic       bus_fetch,
   input logic       cfg_dcmp_en,
   input logic       addr_hit,
   input logic       size_hit,
   input logic       dir_hit,
   input logic       hit,
   input logic       brk_ack,
   input logic       brk_req
);
   // R10
   hit_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> brk_req);
   // R10
   req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req && !brk_ack |=> brk_req);
   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ack && !hit |=> !brk_req);
   // R10
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid && !brk_req |=> !brk_req);
   // R3
   bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_size == 2'd3 |-> !addr_hit);
   // R9
   fetch_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_fetch && cfg_dcmp_en && addr_hit && size_hit && dir_hit |-> hit);
endmodule

bind bus_brk_cmp bbc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid   (bus_valid),
   .bus_size    (bus_size),
   .bus_fetch   (bus_fetch),
   .cfg_dcmp_en (cfg_dcmp_en),
   .addr_hit    (addr_hit),
   .size_hit    (size_hit),
   .dir_hit     (dir_hit),
   .hit         (hit),
   .brk_ack     (brk_ack),
   .brk_req     (brk_req)
);

// File: tb/bus_brk_cmp_tb.sv
module bus_brk_cmp_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [31:0] bus_addr = '0, bus_data = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_write = 1'b0, bus_fetch = 1'b0;
   logic [31:0] cfg_addr = 32'h1003, cfg_data = '0, cfg_mask = '1;
   logic [1:0]  cfg_size = 2'd3, cfg_dir = 2'b11;
   logic        cfg_dcmp_en = 1'b0, brk_ack = 1'b0;
   logic        brk_req;

   int checks = 0, errors = 0;
   bit model_brk = 1'b0;
   string tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_brk_cmp u_dut (.*);

   function automatic bit ref_hit();
      int sh;
      logic [31:0] bv, rv, mv;
      int k;
      if (!bus_valid || bus_size == 2'd3) return 0;
      sh = (bus_size == 2'd2) ? 2 : (bus_size == 2'd1) ? 1 : 0;
      if ((bus_addr >> sh) != (cfg_addr >> sh)) return 0;
      if (cfg_size != 2'd3 && cfg_size != bus_size) return 0;
      if (bus_write && !bus_fetch) begin
         if (!cfg_dir[1]) return 0;
      end else if (!cfg_dir[0]) return 0;
      if (bus_fetch || !cfg_dcmp_en) return 1;
      k = int'(bus_addr[1:0]);
      if (bus_size == 2'd2) begin
         bv = bus_data; rv = cfg_data; mv = cfg_mask;
      end else if (bus_size == 2'd1) begin
         bv = (bus_data >> (16 * (k / 2))) & 32'hFFFF;
         rv = cfg_data & 32'hFFFF; mv = cfg_mask & 32'hFFFF;
      end else begin
         bv = (bus_data >> (8 * k)) & 32'hFF;
         rv = (cfg_data >> (8 * (k % 2))) & 32'hFF;
         mv = (cfg_mask >> (8 * (k % 2))) & 32'hFF;
      end
      return ((bv ^ rv) & ~mv) == 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_brk <= 1'b0;
      else if (ref_hit()) model_brk <= 1'b1;
      else if (brk_ack) model_brk <= 1'b0;
   end

   always @(negedge clk) begin
      checks++;
      if (brk_req !== model_brk) begin
         errors++;
         $display("FAIL %s: brk_req=%0b expected %0b at %0t", tag, brk_req, model_brk, $time);
      end
   end

   task automatic expect_now(bit exp, string t);
      @(negedge clk); #1;
      checks++;
      if (brk_req !== exp) begin
         errors++;
         $display("FAIL %s: brk_req=%0b expected %0b", t, brk_req, exp);
      end
   endtask

   task automatic clear();
      @(posedge clk); #(CLK_PERIOD/4);
      bus_valid = 1'b0; brk_ack = 1'b1;
      @(posedge clk); #(CLK_PERIOD/4);
      brk_ack = 1'b0;
   endtask

   task automatic acc(logic [31:0] a, logic [31:0] d, logic [1:0] s,
                      bit w, bit f, string t, int expv);
      tag = t;
      @(posedge clk); #(CLK_PERIOD/4);
      bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = s;
      bus_write = w; bus_fetch = f;
      @(posedge clk); #(CLK_PERIOD/4);
      bus_valid = 1'b0;
      if (expv >= 0) expect_now(expv[0], t);
      clear();
   endtask

   initial begin
      int wd = 0;
      while (wd < 100000) begin @(posedge clk); wd++; end
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      expect_now(1'b0, "R10 reset");
      #(CLK_PERIOD/4) rst_n = 1'b1;
      // R1 R2 R3: example address, fixed results
      acc(32'h1000, 0, 2'd2, 0, 0, "R1 long@1000", 1);
      acc(32'h1002, 0, 2'd1, 0, 0, "R2 word@1002", 1);
      acc(32'h1003, 0, 2'd0, 0, 0, "R3 byte@1003", 1);
      acc(32'h1000, 0, 2'd1, 0, 0, "R2 word@1000", 0);
      acc(32'h1002, 0, 2'd0, 0, 0, "R3 byte@1002", 0);
      acc(32'h1004, 0, 2'd2, 0, 0, "R1 long@1004", 0);
      acc(32'h1003, 0, 2'd3, 0, 0, "R3 size3", 0);
      // R1 R2 R3 sweep, model compared every clock
      for (int s = 0; s < 3; s++)
         for (int o = -4; o < 8; o++)
            acc(32'h1000 + o, 0, s[1:0], 0, 0, "R1/R2/R3 sweep", -1);
      // R4
      cfg_size = 2'd1;
      acc(32'h1000, 0, 2'd2, 0, 0, "R4 long vs word cond", 0);
      acc(32'h1002, 0, 2'd1, 0, 0, "R4 word vs word cond", 1);
      cfg_size = 2'd3;
      // R5
      cfg_dir = 2'b01;
      acc(32'h1003, 0, 2'd0, 1, 0, "R5 write with reads only", 0);
      acc(32'h1003, 0, 2'd0, 1, 1, "R5 fetch counts as read", 1);
      cfg_dir = 2'b10;
      acc(32'h1003, 0, 2'd0, 0, 0, "R5 read with writes only", 0);
      acc(32'h1003, 0, 2'd0, 1, 0, "R5 write with writes only", 1);
      cfg_dir = 2'b11;
      // R8 byte lanes
      cfg_dcmp_en = 1'b1;
      cfg_data = 32'h5A5A_A5C3; cfg_mask = 32'hFFFF_0000;
      acc(32'h1003, 32'hA511_1111, 2'd0, 0, 0, "R8 lane3 hit", 1);
      acc(32'h1003, 32'hA411_1111, 2'd0, 0, 0, "R8 lane3 miss", 0);
      acc(32'h1003, 32'h11A5_1111, 2'd0, 0, 0, "R8 wrong lane", 0);
      cfg_addr = 32'h1002;
      acc(32'h1002, 32'h11C3_1111, 2'd0, 0, 0, "R8 lane2 low half", 1);
      cfg_mask = 32'h0000_0001;
      acc(32'h1002, 32'h11C2_1111, 2'd0, 0, 0, "R6 masked bit", 1);
      acc(32'h1002, 32'h11C1_1111, 2'd0, 0, 0, "R6 unmasked bit", 0);
      // R7 word lanes, dirty upper cfg bits
      cfg_data = 32'hDEAD_1234; cfg_mask = 32'h0000_0000;
      acc(32'h1002, 32'h1234_5678, 2'd1, 0, 0, "R7 upper half word", 1);
      acc(32'h1002, 32'h5678_1234, 2'd1, 0, 0, "R7 wrong half", 0);
      cfg_addr = 32'h1000;
      acc(32'h1000, 32'hFFFF_1234, 2'd1, 0, 0, "R7 low half word", 1);
      // R6 longword
      acc(32'h1000, 32'hDEAD_1234, 2'd2, 0, 0, "R6 long hit", 1);
      acc(32'h1000, 32'hDEAC_1234, 2'd2, 0, 0, "R6 long miss", 0);
      cfg_mask = 32'h0001_0000;
      acc(32'h1000, 32'hDEAC_1234, 2'd2, 0, 0, "R6 long masked", 1);
      // R9 fetch ignores data
      acc(32'h1000, 32'h0, 2'd2, 0, 1, "R9 fetch", 1);
      cfg_dcmp_en = 1'b0;
      acc(32'h1000, 32'h0, 2'd2, 0, 0, "R6 compare disabled", 1);
      // R10 sticky and hit-over-ack
      tag = "R10 sticky";
      @(posedge clk); #(CLK_PERIOD/4);
      bus_valid = 1'b1; bus_addr = 32'h1000; bus_size = 2'd2; bus_fetch = 1'b0; bus_write = 1'b0;
      @(posedge clk); #(CLK_PERIOD/4);
      bus_valid = 1'b0;
      repeat (4) @(posedge clk);
      expect_now(1'b1, "R10 held without ack");
      #(CLK_PERIOD/4) bus_valid = 1'b1; brk_ack = 1'b1;
      expect_now(1'b1, "R10 hit wins over ack");
      #(CLK_PERIOD/4) bus_valid = 1'b0;
      expect_now(1'b0, "R10 ack clears");
      #(CLK_PERIOD/4) brk_ack = 1'b0;
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule